// File: doc/BRIEF.md
# Duration-Weighted Round-Robin Link Arbiter

This block decides which of four packet-handling agents may use a shared serial-link path. The four agents are a packet-request generator, a packet-retrieve controller, a packet-send controller and a transmit starter. Each one raises its own request line. The arbiter hands out one grant at a time, rotating through the agents in round-robin order. A granted agent then keeps the path for a whole transaction, not for a single cycle.

Each agent has a maximum tenure, set by a parameter. An agent with a longer tenure gets a larger share of the link, so the tenure settings act as a weighting between the agents. A grant ends early when its owner signals done. A new grant is only issued while the link reports ready. The block runs in its own clock domain, which is clocked at half the host bus rate.

Top module: `dwrr_link_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four grant outputs are low.
- R2: At most one grant bit is high in any cycle. Bit i of `gnt` belongs to requester i, for i from 0 to 3.
- R3: No new grant is issued while `link_rdy` is low. A grant that is already running continues unchanged while `link_rdy` is low.
- R4: A new grant goes to the first requester with `req` high, searching upward from the index after the most recently granted requester and wrapping from 3 to 0. After reset the search starts at requester 0.
- R5: A grant to requester i stays high for at most TENURE[i] cycles. With the default parameters these are 4, 3, 2 and 5 cycles for requesters 0, 1, 2 and 3. The grant ends earlier, after the first cycle in which `done[i]` is high.
- R6: While a grant is running, the `done` bits of the other requesters have no effect. A change on the owner's `req` line also has no effect.
- R7: In the cycle that a grant ends, arbitration runs again. If a request is pending and `link_rdy` is high, the next grant appears in the very next cycle, with no idle cycle between grants. The same requester may win again if it is the only one requesting. Otherwise `gnt` falls to zero.
- R8: While no request is pending, all grants stay low and the rotation position does not move. The next grant therefore follows the order that was in force before the idle period.
- R9: When the arbiter is idle and `link_rdy` is high, a grant is issued one clock after the request is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock, at half the host bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request line of each of the four agents |
| done | input | 4 | End-of-transaction signal of each agent; only the owner's bit is used |
| link_rdy | input | 1 | The serial link can accept a new transaction |
| gnt | output | 4 | One-hot grant, one bit per agent |

## Verification
The bench aims at the cycle in which a tenure expires. A design with an off-by-one error in the tenure counter would hold the grant one cycle too long or release it one cycle too early. The bench also drops `link_rdy` in the middle of a grant. A design that gates the running grant with `link_rdy` would cut that grant short. The bench raises `done` on agents that do not hold the grant. A design that reads those bits would release the link early. The bench leaves the arbiter idle between bursts. A design that moves its rotation point while idle would grant the agents in the wrong order afterwards. Random traffic is then checked cycle by cycle against a reference model of the arbiter.

// File: rtl/dwrr_arb_pkg.sv
package dwrr_arb_pkg;

  // (base + off) reduced into the range 0 .. n-1
  function automatic int wrap_add(input int base, input int off, input int n);
    int s;
    s = base + off;
    while (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/dwrr_rr_select.sv
module dwrr_rr_select
  import dwrr_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start_idx,
  output logic          valid,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] cand [N];
  logic [N-1:0]  hit;

  // One candidate slot for each search offset.
  for (genvar k = 0; k < N; k++) begin : g_off
    assign cand[k] = IW'(wrap_add(int'(start_idx), k, N));
    assign hit[k]  = req[cand[k]];
  end

  // The lowest offset with a request wins.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) begin
        valid = 1'b1;
        idx   = cand[k];
      end
    end
  end

endmodule

// File: rtl/dwrr_tenure_ctr.sv
module dwrr_tenure_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dwrr_link_arbiter.sv
module dwrr_link_arbiter
  import dwrr_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 4,
  // Slice i of this vector holds requester i's maximum tenure in cycles (must be >= 1).
  parameter logic [N*CW-1:0] TENURE = {4'd5, 4'd2, 4'd3, 4'd4}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  input  logic         link_rdy,
  output logic [N-1:0] gnt
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  function automatic logic [CW-1:0] limit_of(input logic [IW-1:0] i);
    return TENURE[i*CW +: CW];
  endfunction

  logic          busy_q;
  logic [IW-1:0] own_q;
  logic [IW-1:0] ptr_q;
  logic [CW-1:0] cnt;

  // Named events for the assertions
  logic          own_done;
  logic          at_limit;
  logic          end_now;
  logic          arb_window;
  logic          issue;
  logic [IW-1:0] start_idx;
  logic          sel_valid;
  logic [IW-1:0] sel_idx;

  assign own_done   = busy_q && done[own_q];
  assign at_limit   = busy_q && (cnt == CW'(limit_of(own_q) - 1'b1));
  assign end_now    = own_done || at_limit;
  assign arb_window = !busy_q || end_now;
  assign start_idx  = IW'(wrap_add(int'(ptr_q), 1, N));
  assign issue      = arb_window && link_rdy && sel_valid;

  dwrr_rr_select #(.N(N), .IW(IW)) u_sel (
    .req       (req),
    .start_idx (start_idx),
    .valid     (sel_valid),
    .idx       (sel_idx)
  );

  dwrr_tenure_ctr #(.CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue),
    .inc   (busy_q && !end_now),
    .cnt   (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= IW'(N - 1);
    end else if (issue) begin
      busy_q <= 1'b1;
      own_q  <= sel_idx;
      ptr_q  <= sel_idx;
    end else if (end_now) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (busy_q && own_q == IW'(i)) gnt[i] = 1'b1;
    end
  end

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> gnt == '0);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  p_link_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !link_rdy) |=> gnt == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !end_now) |=> ($stable(gnt) && busy_q));

  p_tenure_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt < limit_of(own_q)));

  p_idle_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req == '0) |=> $stable(ptr_q));

  p_grant_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && link_rdy && req != '0) |=> ((gnt & $past(req)) != '0));

endmodule

// File: tb/dwrr_link_arbiter_test.sv
`timescale 1ns/1ps
module dwrr_link_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] done = '0;
  logic       link_rdy = 1'b0;
  logic [3:0] gnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [3:0] m_gnt = '0;
  int m_own = 0;
  int m_ptr = 3;
  int m_cnt = 0;

  always #10 clk = ~clk;

  dwrr_link_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .link_rdy(link_rdy), .gnt(gnt)
  );

  function automatic int lim(input int i);
    case (i)
      0: return 4;
      1: return 3;
      2: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int pick(input logic [3:0] r, input int last);
    for (int k = 1; k <= 4; k++) begin
      if (r[(last + k) % 4]) return (last + k) % 4;
    end
    return -1;
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive the inputs, advance one clock, then compare against the model.
  task automatic step(input logic [3:0] r, input logic [3:0] d, input logic l, input string tag);
    logic [3:0] ng;
    int no, np, nc;
    bit win;
    req = r; done = d; link_rdy = l;
    ng = m_gnt; no = m_own; np = m_ptr; nc = m_cnt; win = 1;
    if (m_gnt != 0) begin
      if (d[m_own] || m_cnt == lim(m_own) - 1) ng = '0;
      else begin nc = m_cnt + 1; win = 0; end
    end
    if (win && l && r != 0) begin
      no = pick(r, m_ptr); np = no; nc = 0; ng = 4'b0001 << no;
    end
    @(posedge clk);
    @(negedge clk);
    m_gnt = ng; m_own = no; m_ptr = np; m_cnt = nc;
    chk(gnt, m_gnt, tag);
    n_chk++;
    if ($countones(gnt) > 1) begin
      n_bad++;
      $display("FAIL R2: gnt=%b expected=at most one bit", gnt);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    req = 4'b1111; link_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk(gnt, 4'b0000, "R1 in reset");
    rst_n = 1'b1;
    chk(gnt, 4'b0000, "R1 after release");

    // R9 / R4: first grant starts the search at requester 0
    step(4'b0110, 4'b0000, 1'b1, "R9 R4 first grant");
    chk(gnt, 4'b0010, "R4 explicit");
    // R6: the owner drops req and other agents raise done: the grant is kept
    step(4'b0100, 4'b1101, 1'b1, "R6 foreign done");
    chk(gnt, 4'b0010, "R6 explicit");
    step(4'b0100, 4'b0000, 1'b1, "R5 tenure last cycle");
    // R7: handoff with no idle cycle
    step(4'b0100, 4'b0000, 1'b1, "R7 handoff");
    chk(gnt, 4'b0100, "R7 explicit");
    step(4'b0000, 4'b0000, 1'b1, "R5 tenure of 2");
    step(4'b0000, 4'b0000, 1'b1, "R7 drop to idle");
    chk(gnt, 4'b0000, "R7 idle explicit");

    // R8: a long idle must not move the rotation point
    for (int i = 0; i < 6; i++) step(4'b0000, 4'b0000, 1'b1, "R8 idle");
    step(4'b1011, 4'b0000, 1'b1, "R8 resume order");
    chk(gnt, 4'b1000, "R8 explicit");

    // R5: full tenure of requester 3, then rotation to 0
    for (int i = 0; i < 6; i++) step(4'b1111, 4'b0000, 1'b1, "R5 R4 full tenure");
    chk(gnt, 4'b0001, "R4 wrap to 0");

    // R3: link drop while busy keeps the grant; while idle it blocks new grants
    step(4'b1111, 4'b0000, 1'b0, "R3 hold while link low");
    chk(gnt, 4'b0001, "R3 explicit hold");
    step(4'b1111, 4'b0001, 1'b0, "R5 owner done early");
    step(4'b1111, 4'b0000, 1'b0, "R3 blocked");
    chk(gnt, 4'b0000, "R3 explicit block");
    step(4'b1111, 4'b0000, 1'b1, "R3 release");
    chk(gnt, 4'b0010, "R4 next after 0");

    // single requester re-wins after its tenure (R7)
    for (int i = 0; i < 8; i++) step(4'b0010, 4'b0000, 1'b1, "R7 same winner");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r, d;
      logic l;
      r = 4'($urandom());
      d = (($urandom() % 5) == 0) ? 4'($urandom()) : 4'b0000;
      l = (($urandom() % 6) != 0);
      step(r, d, l, "R2 R3 R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule